// File: doc/BRIEF.md
# Trace Capture Ring Buffer

The block records one wide trace word on every clock cycle into a circular store of entries. Two register ports read the store: one for the processor and one for a debug agent. Each port has an address register and a data register. Software first stops capture, then points the read pointer at a doubleword and reads the data register over and over. Each read returns one doubleword and moves the pointer on by one.

The write pointer is counted in whole entries. The read pointer is counted in 64-bit doublewords. The upper half of the address register shows the write pointer with the store depth ORed in. Software can therefore find the depth from the highest set bit of that field. Capture stops while either port holds its freeze bit. Each port keeps its own read pointer and its own freeze bit.

The depth must be a power of two. The entry width must be a multiple of 64 bits. A port selects a register with a one-bit select: 0 is the address register and 1 is the data register. A read answers exactly one cycle after its request, together with a valid strobe.

Top module: `tlog_ring`

## Requirements
- R1: After reset the write pointer, both read pointers and both freeze bits are zero, and neither port asserts its valid strobe.
- R2: In each cycle in which capture is not held, the trace word is stored at the entry the write pointer names. The write pointer then advances by one, wrapping modulo DEPTH.
- R3: Reading the address register (select 0) returns bits [63:32] = DEPTH OR write pointer, bit 31 = that port's freeze bit, and bits [30:0] = that port's read pointer.
- R4: Reading the data register (select 1) returns doubleword (rp mod W) of entry (rp / W), where W = entry width / 64 and doubleword 0 is entry bits [63:0]. The read pointer rp then steps by one, wrapping modulo DEPTH*W.
- R5: Writing the address register loads the freeze bit from bit 31 and the read pointer from bits [30:0] modulo DEPTH*W. Bits [63:32] of the written value are ignored and the write pointer is unaffected.
- R6: Capture is held from the cycle after either port's freeze bit is set until both are clear. While it is held, no entry is written and the write pointer stays put.
- R7: The two ports keep separate read pointers and freeze bits. Both ports may read in the same cycle without affecting each other.
- R8: A read request is answered on the next cycle with the valid strobe high for exactly that cycle. A cycle with no read request gives no valid strobe on the next cycle.
- R9: When a data read targets the entry being captured in the same cycle, it returns the contents that entry held before that cycle's capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_word | input | ENTRY_W | Word captured this cycle |
| cpu_rd | input | 1 | Processor port read request |
| cpu_wr | input | 1 | Processor port write request |
| cpu_sel | input | 1 | Processor register select: 0 address, 1 data |
| cpu_wdata | input | 64 | Processor write value |
| cpu_rdata | output | 64 | Processor read response |
| cpu_rvalid | output | 1 | Processor response valid |
| dbg_rd | input | 1 | Debug port read request |
| dbg_wr | input | 1 | Debug port write request |
| dbg_sel | input | 1 | Debug register select: 0 address, 1 data |
| dbg_wdata | input | 64 | Debug write value |
| dbg_rdata | output | 64 | Debug read response |
| dbg_rvalid | output | 1 | Debug response valid |

## Verification
Capture and a data read can fall on the same entry in the same cycle. The bench provokes this by unfreezing, waiting until the store has wrapped, and loading the read pointer with the first doubleword of the entry that will be captured one cycle later. The data read that follows must return the stamp of the earlier pass, not the one being written. A freeze-bit write and a capture also coincide, and the entry captured on that same edge is checked to be present. The bench also sets the processor freeze bit with the debug bit clear, and then the reverse, and judges that the reported write pointer stays put both times.

// File: rtl/tlog_pkg.sv
package tlog_pkg;
   localparam int TLOG_DW = 64;

   typedef enum logic {
      REG_ADDR = 1'b0,
      REG_DATA = 1'b1
   } tlog_reg_e;
endpackage

// File: rtl/tlog_store.sv
module tlog_store #(
   parameter int DEPTH   = 2048,
   parameter int ENTRY_W = 256,
   parameter int NRD     = 2,
   localparam int WP_W   = $clog2(DEPTH)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            capture_en,
   input  logic [ENTRY_W-1:0]              din,
   output logic [WP_W-1:0]                 wptr,
   input  logic [NRD-1:0][WP_W-1:0]        rd_idx,
   output logic [NRD-1:0][ENTRY_W-1:0]     rd_line
);
   logic [ENTRY_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (capture_en) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wptr <= '0;
      else if (capture_en) wptr <= wptr + 1'b1;
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rd_line[g] = mem[rd_idx[g]];
   end
endmodule

// File: rtl/tlog_port.sv
module tlog_port
   import tlog_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int ENTRY_W = 256,
   localparam int WORDS  = ENTRY_W / TLOG_DW,
   localparam int WP_W   = $clog2(DEPTH),
   localparam int WS_W   = $clog2(WORDS),
   localparam int RP_W   = WP_W + WS_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd,
   input  logic                wr,
   input  logic                sel,
   input  logic [TLOG_DW-1:0]  wdata,
   input  logic [WP_W-1:0]     wptr,
   input  logic [ENTRY_W-1:0]  line,
   output logic [WP_W-1:0]     line_idx,
   output logic                freeze,
   output logic [TLOG_DW-1:0]  rdata,
   output logic                rvalid
);
   logic [RP_W-1:0]                rptr;
   logic [WORDS-1:0][TLOG_DW-1:0]  line_w;
   logic [TLOG_DW-1:0]             word;
   logic [TLOG_DW-1:0]             addr_view;
   logic                           unused_wbits;

   assign line_w       = line;
   assign unused_wbits = ^{wdata[TLOG_DW-1:32], wdata[30:RP_W]};

   if (WORDS == 1) begin : g_one_word
      assign word     = line_w[0];
      assign line_idx = rptr;
   end else begin : g_multi_word
      assign word     = line_w[rptr[WS_W-1:0]];
      assign line_idx = rptr[RP_W-1:WS_W];
   end

   assign addr_view = {32'(DEPTH) | 32'(wptr), freeze, 31'(rptr)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr   <= '0;
         freeze <= 1'b0;
      end else if (wr && sel == REG_ADDR) begin
         rptr   <= wdata[RP_W-1:0];
         freeze <= wdata[31];
      end else if (rd && sel == REG_DATA) begin
         rptr   <= rptr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd;
         if (rd) rdata <= (sel == REG_DATA) ? word : addr_view;
      end
   end
endmodule

// File: rtl/tlog_ring.sv
module tlog_ring
   import tlog_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int ENTRY_W = 256,
   localparam int WORDS  = ENTRY_W / TLOG_DW,
   localparam int WP_W   = $clog2(DEPTH),
   localparam int RP_W   = WP_W + $clog2(WORDS),
   localparam int NPORT  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ENTRY_W-1:0]  trace_word,
   input  logic                cpu_rd,
   input  logic                cpu_wr,
   input  logic                cpu_sel,
   input  logic [TLOG_DW-1:0]  cpu_wdata,
   output logic [TLOG_DW-1:0]  cpu_rdata,
   output logic                cpu_rvalid,
   input  logic                dbg_rd,
   input  logic                dbg_wr,
   input  logic                dbg_sel,
   input  logic [TLOG_DW-1:0]  dbg_wdata,
   output logic [TLOG_DW-1:0]  dbg_rdata,
   output logic                dbg_rvalid
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tlog_ring: DEPTH must be a power of two, at least 2");
   end
   if (ENTRY_W < TLOG_DW || ENTRY_W % TLOG_DW != 0 ||
       (WORDS & (WORDS - 1)) != 0) begin : g_bad_width
      $error("tlog_ring: ENTRY_W must be a power-of-two multiple of 64");
   end
   if (RP_W > 30) begin : g_bad_range
      $error("tlog_ring: read pointer does not fit bits 30:0");
   end

   logic [NPORT-1:0]               p_rd, p_wr, p_sel, p_frz, p_rvalid;
   logic [NPORT-1:0][TLOG_DW-1:0]  p_wdata, p_rdata;
   logic [NPORT-1:0][WP_W-1:0]     p_idx;
   logic [NPORT-1:0][ENTRY_W-1:0]  p_line;
   logic [WP_W-1:0]                wr_ptr;
   logic                           cap_hold;

   assign p_rd    = {dbg_rd, cpu_rd};
   assign p_wr    = {dbg_wr, cpu_wr};
   assign p_sel   = {dbg_sel, cpu_sel};
   assign p_wdata = {dbg_wdata, cpu_wdata};
   assign cap_hold = |p_frz;

   tlog_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .NRD(NPORT)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_en (!cap_hold),
      .din        (trace_word),
      .wptr       (wr_ptr),
      .rd_idx     (p_idx),
      .rd_line    (p_line)
   );

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      tlog_port #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd       (p_rd[g]),
         .wr       (p_wr[g]),
         .sel      (p_sel[g]),
         .wdata    (p_wdata[g]),
         .wptr     (wr_ptr),
         .line     (p_line[g]),
         .line_idx (p_idx[g]),
         .freeze   (p_frz[g]),
         .rdata    (p_rdata[g]),
         .rvalid   (p_rvalid[g])
      );
   end

   assign cpu_rdata  = p_rdata[0];
   assign cpu_rvalid = p_rvalid[0];
   assign dbg_rdata  = p_rdata[1];
   assign dbg_rvalid = p_rvalid[1];
endmodule

// File: rtl/tlog_ring_chk.sv
module tlog_ring_chk #(
   parameter int DEPTH  = 2048,
   localparam int WP_W  = $clog2(DEPTH)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_rd,
   input logic            cpu_sel,
   input logic            cpu_rvalid,
   input logic            dbg_rd,
   input logic            dbg_rvalid,
   input logic            depth_bit,
   input logic            cap_hold,
   input logic [WP_W-1:0] wr_ptr
);
   a_r8_cpu_answer: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> cpu_rvalid);
   a_r8_cpu_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> !cpu_rvalid);
   a_r8_dbg_answer: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_rd |=> dbg_rvalid);
   a_r8_dbg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_rd |=> !dbg_rvalid);
   a_r6_hold_keeps_wptr: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hold |=> $stable(wr_ptr));
   a_r2_wptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_hold |=> wr_ptr == WP_W'($past(wr_ptr) + 1'b1));
   a_r3_depth_marker: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rvalid && !$past(cpu_sel)) |-> depth_bit);
endmodule

bind tlog_ring tlog_ring_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_rd     (cpu_rd),
   .cpu_sel    (cpu_sel),
   .cpu_rvalid (cpu_rvalid),
   .dbg_rd     (dbg_rd),
   .dbg_rvalid (dbg_rvalid),
   .depth_bit  (cpu_rdata[32 + $clog2(DEPTH)]),
   .cap_hold   (cap_hold),
   .wr_ptr     (wr_ptr)
);

// File: tb/sim_tlog_ring.sv
`timescale 1ns/1ps
module sim_tlog_ring;
   localparam int D   = 8;
   localparam int EW  = 256;
   localparam int W   = EW / 64;
   localparam int RPN = D * W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [EW-1:0] trace_word;
   logic [1:0]    b_rd = '0, b_wr = '0, b_sel = '0;
   logic [63:0]   b_wd [2];
   logic [63:0]   out_d [2];
   logic [1:0]    out_v;
   logic [63:0]   cpu_rdata, dbg_rdata;
   logic          cpu_rvalid, dbg_rvalid;

   int tcnt = 0;
   int n_chk = 0, n_fail = 0;
   int mc [D];
   int mwp;
   int mrp [2];
   bit mf [2];
   bit exp_v [2];
   logic [63:0] exp_d [2];

   function automatic logic [63:0] pat(input int k, input int d);
      return {k[31:0], 32'h5A5A_0000 | d[31:0]};
   endfunction

   always_comb begin
      for (int d = 0; d < W; d++) trace_word[d*64 +: 64] = pat(tcnt, d);
   end
   always @(negedge clk) tcnt <= tcnt + 1;

   tlog_ring #(.DEPTH(D), .ENTRY_W(EW)) u0 (
      .clk(clk), .rst_n(rst_n), .trace_word(trace_word),
      .cpu_rd(b_rd[0]), .cpu_wr(b_wr[0]), .cpu_sel(b_sel[0]), .cpu_wdata(b_wd[0]),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
      .dbg_rd(b_rd[1]), .dbg_wr(b_wr[1]), .dbg_sel(b_sel[1]), .dbg_wdata(b_wd[1]),
      .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid)
   );

   assign out_d[0] = cpu_rdata;
   assign out_d[1] = dbg_rdata;
   assign out_v    = {dbg_rvalid, cpu_rvalid};

   // Reference model: responses use state before this edge (R9), then capture, then pointer updates.
   always @(posedge clk) begin
      if (!rst_n) begin
         mwp = 0;
         for (int p = 0; p < 2; p++) begin
            mrp[p] = 0; mf[p] = 0; exp_v[p] = 0;
         end
      end else begin
         for (int p = 0; p < 2; p++) begin
            exp_v[p] = b_rd[p];
            if (b_rd[p]) begin
               if (b_sel[p]) exp_d[p] = pat(mc[mrp[p] / W], mrp[p] % W);
               else          exp_d[p] = {32'(D) | 32'(mwp), mf[p], 31'(mrp[p])};
            end
         end
         if (!(mf[0] || mf[1])) begin
            mc[mwp] = tcnt;
            mwp = (mwp + 1) % D;
         end
         for (int p = 0; p < 2; p++) begin
            if (b_wr[p] && !b_sel[p]) begin
               mf[p]  = b_wd[p][31];
               mrp[p] = int'(b_wd[p][30:0]) % RPN;
            end else if (b_rd[p] && b_sel[p]) begin
               mrp[p] = (mrp[p] + 1) % RPN;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one cycle of requests at a falling edge; judge responses at the next falling edge.
   task automatic step(input logic [1:0] r, input logic [1:0] w, input logic [1:0] s,
                       input logic [63:0] d0, input logic [63:0] d1, input string tag);
      b_rd = r; b_wr = w; b_sel = s; b_wd[0] = d0; b_wd[1] = d1;
      @(negedge clk);
      b_rd = '0; b_wr = '0;
      for (int p = 0; p < 2; p++) begin
         chk(out_v[p] == exp_v[p], {tag, " R8 valid"}, 64'(out_v[p]), 64'(exp_v[p]));
         if (exp_v[p]) chk(out_d[p] === exp_d[p], tag, out_d[p], exp_d[p]);
      end
   endtask

   function automatic logic [63:0] aw(input bit frz, input int rp);
      return {32'hC0DE_F00D, frz, 31'(rp)};
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(2'b00, 2'b00, 2'b00, '0, '0, "idle");
   endtask

   initial begin
      b_wd[0] = '0; b_wd[1] = '0;
      repeat (3) @(negedge clk);
      chk(out_v == 2'b00, "R1 no valid in reset", 64'(out_v), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 and R3: reset view of both address registers
      chk(out_v == 2'b00, "R1 no valid after reset", 64'(out_v), 64'd0);
      step(2'b11, 2'b00, 2'b00, '0, '0, "R1 R3 reset address view");
      // R2: run long enough to wrap the write pointer
      idle(2 * D + 3);
      // R6: freeze on cpu; the capture on this same edge still lands
      step(2'b00, 2'b01, 2'b00, aw(1, 0), '0, "R6 freeze");
      step(2'b01, 2'b00, 2'b00, '0, '0, "R2 R3 write pointer after run");
      // R4: full sweep of all doublewords plus wrap
      for (int i = 0; i < RPN + 2; i++) step(2'b01, 2'b00, 2'b01, '0, '0, "R4 data sweep");
      idle(4);
      step(2'b01, 2'b00, 2'b00, '0, '0, "R6 write pointer held");
      // R5: load read pointer, upper bits ignored
      step(2'b00, 2'b01, 2'b00, aw(1, RPN + 5), '0, "R5 address write");
      step(2'b01, 2'b00, 2'b00, '0, '0, "R5 address readback");
      // R7: debug port own pointer, both ports read data together
      step(2'b00, 2'b10, 2'b00, '0, aw(0, 9), "R7 dbg pointer load");
      for (int i = 0; i < 3; i++) step(2'b11, 2'b00, 2'b11, '0, '0, "R7 dual data read");
      // R6: hold via debug port alone
      step(2'b00, 2'b11, 2'b00, aw(0, 0), aw(1, 0), "R6 swap freeze owner");
      idle(3);
      step(2'b11, 2'b00, 2'b00, '0, '0, "R6 debug freeze holds");
      idle(2);
      step(2'b11, 2'b00, 2'b00, '0, '0, "R6 R7 held view");
      // R9: release capture, let it wrap, then collide capture and data read
      step(2'b00, 2'b10, 2'b00, '0, aw(0, 0), "R6 release");
      idle(D + 2);
      for (int k = 0; k < 3; k++) begin
         step(2'b00, 2'b01, 2'b00, aw(0, ((mwp + 1) % D) * W), '0, "R9 aim at next capture");
         step(2'b01, 2'b00, 2'b01, '0, '0, "R9 same-cycle capture and read");
      end
      step(2'b11, 2'b00, 2'b00, '0, '0, "R2 R3 final view");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule